// File: doc/BRIEF.md
# Registered single-transaction memory-mapped bridge

This block is placed between one memory-mapped master and one memory-mapped slave, both with 32-bit data and single-beat transfers. Its job is to cut every combinational path between the two sides. A request from the master is first stored in registers. The stored copy is then presented downstream a fixed number of cycles later.

The upstream waitrequest comes straight from a flip-flop. It stays high on every access until the downstream slave has accepted the transfer. Only one transaction is in flight at any time. The block gives up throughput and adds latency so that a wide interconnect can close timing at a high clock rate. The stored address stays constant for the whole downstream access, so it can be given a relaxed timing constraint.

Top module: `mm_timing_bridge`

## Requirements
- R1: While reset is applied, and after it is released with no request pending, `up_waitreq` is 1 and both `dn_read` and `dn_write` are 0.
- R2: For a request that an idle bridge sees in cycle c, the matching downstream strobe is high from cycle c+2. A read raises `dn_read` and a write raises `dn_write`, and the two are never high together. In that cycle `dn_addr`, `dn_wdata` and `dn_be` equal the address, write data and byte enables of cycle c, with the byte enables unchanged.
- R3: While a downstream strobe is high and `dn_waitreq` is 1, the strobe, `dn_addr`, `dn_wdata` and `dn_be` hold their values into the next cycle.
- R4: `up_waitreq` is low for exactly one cycle per transaction. For a downstream slave that holds `dn_waitreq` high for N strobe cycles, that cycle is c+3+N, and this holds even when N is 0. `up_waitreq` is high whenever a downstream strobe is high.
- R5: For a read, `up_rdata` in the cycle where `up_waitreq` is low equals the `dn_rdata` present in the cycle where the downstream slave accepted the read.
- R6: A write completes upstream only after the downstream slave has accepted it, and the slave receives the written data and byte enables exactly once.
- R7: A request with read and write both high raises no downstream strobe. It completes with `up_waitreq` low in cycle c+2, and `up_rdata` keeps its previous value.
- R8: Upstream inputs are sampled only in the cycle the idle bridge accepts a request. Later changes on `up_addr` or `up_wdata` during that transaction do not reach the downstream port.
- R9: A new request presented in the cycle right after a completion is handled with the same timing as one that follows idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| up_addr | input | ADDR_W | Upstream address |
| up_read | input | 1 | Upstream read request |
| up_write | input | 1 | Upstream write request |
| up_wdata | input | 32 | Upstream write data |
| up_be | input | 4 | Upstream byte enables |
| up_waitreq | output | 1 | Upstream stall, driven from a register |
| up_rdata | output | 32 | Upstream read data, registered |
| dn_addr | output | ADDR_W | Downstream address |
| dn_read | output | 1 | Downstream read strobe |
| dn_write | output | 1 | Downstream write strobe |
| dn_wdata | output | 32 | Downstream write data |
| dn_be | output | 4 | Downstream byte enables |
| dn_waitreq | input | 1 | Downstream stall |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions rely on the downstream slave keeping to the usual stall rule. It may hold `dn_waitreq` high for any number of cycles, and it reports `dn_rdata` valid in the cycle it drops `dn_waitreq`. They also rely on the upstream master keeping its request asserted until it sees `up_waitreq` low. The bench's slave model drops its stall after a per-transfer count of 0 to 5 strobe cycles. The bench master always holds its request through the completion cycle and releases it one cycle later. The one test that changes address and data in the middle of a transfer (R8) does so only to show that the bridge ignores those changes.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
  localparam int MMB_DW  = 32;
  localparam int MMB_BEW = MMB_DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_ISSUE   = 2'd2,
    ST_RESPOND = 2'd3
  } mmb_state_t;

  typedef struct packed {
    logic [MMB_DW-1:0]  wdata;
    logic [MMB_BEW-1:0] be;
    logic               rd;
    logic               wr;
  } mmb_req_t;
endpackage

// File: rtl/mmb_rst_sync.sv
module mmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mmb_req_capture.sv
module mmb_req_capture
  import mmb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] in_addr,
  input  mmb_req_t          in_req,
  output logic [ADDR_W-1:0] held_addr,
  output mmb_req_t          held_req
);
  logic [ADDR_W-1:0] addr_q;
  mmb_req_t          req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      req_q  <= '0;
    end else if (load_en) begin
      addr_q <= in_addr;
      req_q  <= in_req;
    end
  end

  assign held_addr = addr_q;
  assign held_req  = req_q;
endmodule

// File: rtl/mmb_rdata_reg.sv
module mmb_rdata_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= d;
  end

  assign q = data_q;
endmodule

// File: rtl/mmb_ctrl.sv
module mmb_ctrl
  import mmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_read,
  input  logic       up_write,
  input  logic       held_rd,
  input  logic       held_wr,
  input  logic       dn_waitreq,
  output mmb_state_t state,
  output logic       cap_en,
  output logic       rdata_en,
  output logic       up_waitreq
);
  mmb_state_t state_q, state_d;
  logic       wait_q, wait_d;
  logic       conflict;

  assign conflict = held_rd & held_wr;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (up_read | up_write) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = conflict ? ST_RESPOND : ST_ISSUE;
      ST_ISSUE:   if (!dn_waitreq) state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign wait_d   = (state_d != ST_RESPOND);
  assign cap_en   = (state_q == ST_IDLE) & (up_read | up_write);
  assign rdata_en = (state_q == ST_ISSUE) & ~dn_waitreq & held_rd;

  // state and stall registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
    end
  end

  assign state      = state_q;
  assign up_waitreq = wait_q;

  // R4: a completion cycle is always followed by a stall cycle
  assert_single_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_q |=> wait_q);

  // R7: a conflicting request never enters the issue state
  assert_conflict_skips_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPTURE && conflict) |=> (state_q == ST_RESPOND));
endmodule

// File: rtl/mm_timing_bridge.sv
module mm_timing_bridge
  import mmb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   up_addr,
  input  logic                up_read,
  input  logic                up_write,
  input  logic [MMB_DW-1:0]   up_wdata,
  input  logic [MMB_BEW-1:0]  up_be,
  output logic                up_waitreq,
  output logic [MMB_DW-1:0]   up_rdata,
  output logic [ADDR_W-1:0]   dn_addr,
  output logic                dn_read,
  output logic                dn_write,
  output logic [MMB_DW-1:0]   dn_wdata,
  output logic [MMB_BEW-1:0]  dn_be,
  input  logic                dn_waitreq,
  input  logic [MMB_DW-1:0]   dn_rdata
);
  logic       rst_sync_n;
  logic       cap_en, rdata_en;
  mmb_state_t state;
  mmb_req_t   in_req, held_req;

  mmb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_req = '{wdata: up_wdata, be: up_be, rd: up_read, wr: up_write};

  mmb_req_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (cap_en),
    .in_addr   (up_addr),
    .in_req    (in_req),
    .held_addr (dn_addr),
    .held_req  (held_req)
  );

  mmb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .up_read    (up_read),
    .up_write   (up_write),
    .held_rd    (held_req.rd),
    .held_wr    (held_req.wr),
    .dn_waitreq (dn_waitreq),
    .state      (state),
    .cap_en     (cap_en),
    .rdata_en   (rdata_en),
    .up_waitreq (up_waitreq)
  );

  mmb_rdata_reg #(.DW(MMB_DW)) u_rdata (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (rdata_en),
    .d       (dn_rdata),
    .q       (up_rdata)
  );

  // strobes decode only registered state; a conflicting request never reaches ISSUE
  assign dn_read  = (state == ST_ISSUE) & held_req.rd;
  assign dn_write = (state == ST_ISSUE) & held_req.wr;
  assign dn_wdata = held_req.wdata;
  assign dn_be    = held_req.be;

  // R2: never both strobes
  assert_excl_strobe_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dn_read && dn_write));

  // R3: a stalled strobe is held
  assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dn_read || dn_write) && dn_waitreq) |=> ($stable(dn_read) && $stable(dn_write)));

  // R3: request fields steady while the slave stalls
  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dn_read || dn_write) && dn_waitreq) |=>
      ($stable(dn_addr) && $stable(dn_wdata) && $stable(dn_be)));

  // R4: upstream stays stalled while downstream is busy
  assert_stall_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dn_read || dn_write) |-> up_waitreq);
endmodule

// File: tb/sim_mm_timing_bridge.sv
module sim_mm_timing_bridge;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic          up_read = 1'b0, up_write = 1'b0;
  logic [31:0]   up_wdata = '0;
  logic [3:0]    up_be = '0;
  logic          up_waitreq;
  logic [31:0]   up_rdata;
  logic [AW-1:0] dn_addr;
  logic          dn_read, dn_write;
  logic [31:0]   dn_wdata;
  logic [3:0]    dn_be;
  logic          dn_waitreq;
  logic [31:0]   dn_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mm_timing_bridge #(.ADDR_W(AW)) u0 (.*);

  // downstream slave model
  logic [3:0]    cur_wait = '0;
  logic [3:0]    wcnt = '0;
  int            acc_cnt = 0, strobe_cyc = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic [3:0]    acc_be = '0;
  logic          acc_wr = 1'b0;

  assign dn_waitreq = (dn_read | dn_write) && (wcnt < cur_wait);

  always @(posedge clk) begin
    if (dn_read | dn_write) begin
      strobe_cyc <= strobe_cyc + 1;
      if (dn_waitreq) wcnt <= wcnt + 4'd1;
      else begin
        wcnt      <= '0;
        acc_cnt   <= acc_cnt + 1;
        acc_addr  <= dn_addr;
        acc_wdata <= dn_wdata;
        acc_be    <= dn_be;
        acc_wr    <= dn_write;
      end
    end else wcnt <= '0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one upstream transfer; request presented in the cycle after this call's first negedge
  task automatic xfer(input bit wr, input bit rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [3:0] be, input logic [3:0] nw,
                      input bit perturb, input string tag);
    int k = 0;
    int acc0, str0;
    bit conflict = wr & rd;
    logic [31:0] prev_rdata = up_rdata;
    int exp_k = conflict ? 2 : 3 + int'(nw);
    acc0 = acc_cnt; str0 = strobe_cyc;
    cur_wait = nw;
    dn_rdata = d ^ 32'h5A5A_0F0F;
    up_addr = a; up_wdata = d; up_be = be; up_write = wr; up_read = rd;
    while (k < 40) begin
      @(negedge clk);
      k++;
      if (perturb && k == 1) begin up_addr = ~a; up_wdata = ~d; end
      if (k == 1)
        chk(!(dn_read | dn_write), "R2", {tag, " strobe early"}, {dn_read, dn_write}, 0);
      if (k == 2 && !conflict) begin
        chk(dn_read == rd && dn_write == wr, "R2", {tag, " strobe at c+2"},
            {dn_read, dn_write}, {rd, wr});
        chk(dn_addr == a && dn_be == be, "R2", {tag, " addr/be"}, {dn_addr, dn_be}, {a, be});
        if (wr) chk(dn_wdata == d, "R2", {tag, " wdata"}, dn_wdata, d);
      end
      if (!up_waitreq) break;
    end
    chk(k == exp_k, conflict ? "R7" : "R4", {tag, " completion cycle"}, k, exp_k);
    if (conflict) begin
      chk(strobe_cyc == str0, "R7", {tag, " no strobe"}, strobe_cyc - str0, 0);
      chk(up_rdata == prev_rdata, "R7", {tag, " rdata kept"}, up_rdata, prev_rdata);
    end else begin
      chk(acc_cnt == acc0 + 1, "R6", {tag, " accepted once"}, acc_cnt - acc0, 1);
      chk(acc_addr == a, "R8", {tag, " downstream addr"}, acc_addr, a);
      if (wr) chk(acc_wr && acc_wdata == d && acc_be == be, "R6", {tag, " write data"},
                  {acc_wr, acc_wdata, acc_be}, {1'b1, d, be});
      if (rd) chk(up_rdata == (d ^ 32'h5A5A_0F0F), "R5", {tag, " read data"},
                  up_rdata, d ^ 32'h5A5A_0F0F);
    end
    @(negedge clk);
    up_read = 1'b0; up_write = 1'b0;
    chk(up_waitreq == 1'b1, "R4", {tag, " single release"}, up_waitreq, 1);
  endtask

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [3:0]    be;
    logic [3:0]    nw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 16'h0010, 32'hDEAD_BEEF, 4'hF, 4'd0},
    '{1'b0, 16'h0010, 32'h1234_5678, 4'hF, 4'd0},
    '{1'b1, 16'h0A04, 32'hCAFE_0001, 4'h3, 4'd2},
    '{1'b0, 16'h0A04, 32'h8765_4321, 4'hC, 4'd5},
    '{1'b1, 16'hFFFC, 32'h0000_FFFF, 4'h1, 4'd1},
    '{1'b0, 16'h7F00, 32'hA5A5_A5A5, 4'h8, 4'd3}
  };

  initial begin
    // R1: reset state while held and after release
    repeat (3) @(negedge clk);
    chk(up_waitreq && !dn_read && !dn_write, "R1", "in reset",
        {up_waitreq, dn_read, dn_write}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(up_waitreq && !dn_read && !dn_write, "R1", "after reset",
        {up_waitreq, dn_read, dn_write}, 3'b100);

    foreach (VECS[i])
      xfer(VECS[i].wr, !VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].be,
           VECS[i].nw, 1'b0, $sformatf("vec%0d", i));

    // R7: read and write both high
    xfer(1'b1, 1'b1, 16'h0200, 32'h0BAD_F00D, 4'hF, 4'd0, 1'b0, "conflict");
    // R8: inputs changed mid-transfer
    xfer(1'b1, 1'b0, 16'h0300, 32'h1357_9BDF, 4'h5, 4'd2, 1'b1, "perturb");
    // R9: back-to-back after completion (xfer returns in idle cycle right after completion)
    xfer(1'b0, 1'b0 | 1'b1, 16'h0404, 32'h2468_ACE0, 4'hF, 4'd0, 1'b0, "b2b_a");
    xfer(1'b1, 1'b0, 16'h0408, 32'hFEDC_BA98, 4'hE, 4'd0, 1'b0, "b2b_b_R9");

    repeat (3) @(negedge clk);
    chk(up_waitreq && !dn_read && !dn_write, "R1", "idle at end",
        {up_waitreq, dn_read, dn_write}, 3'b100);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule